// File: doc/BRIEF.md
# Serial Tune Select and Playback Gate

This block sits in front of a melody sequencer. A host selects one of sixteen tunes by shifting a four-bit code into it over a two-wire serial link: one data line and one shift clock. A level input then controls playback. Raising it starts the block's delay count. After a fixed number of reference-clock ticks, the block issues a one-cycle start pulse to the sequencer, together with the selected tune number. Dropping the level stops playback at once.

The reference clock arrives as a one-cycle tick enable, `ref_tick`, inside the system clock domain. The block passes that tick to the sequencer as `core_tick`, but only while a tune is playing. When playback is off, no internal tick runs. The serial and start/stop pins pass through a two-flop synchronizer, so every reaction to a pin is measured from the synchronized level.

The selection register shifts only while the block is idle. While the delay count runs or a tune plays, the register is frozen. Its value survives a stop and is used again at the next start.

Top module: `tune_play_ctrl`

## Requirements
- R1: On each rising edge of `sc`, the data bit on `si` shifts into the selection, most significant bit first. `tune_code` holds the last four bits shifted in, with the first of those four in bit 3. Earlier bits are discarded.
- R2: `tune_num` equals `tune_code` plus one. Code 0 gives tune 1 and code 15 gives tune 16.
- R3: Shift-clock edges that arrive while the block is waiting or playing leave `tune_code` unchanged.
- R4: `tune_code` keeps its value after playback stops. The next start reports the same tune number.
- R5: After `st` rises, `start_pulse` goes high for exactly one cycle once `START_DELAY` ticks of `ref_tick` have elapsed, within one tick. `playing` rises in the same cycle.
- R6: When `st` falls, `stop_pulse` fires and `playing` drops within the synchronizer latency plus one cycle. `core_tick` stops even if `ref_tick` keeps running.
- R7: `core_tick` stays low whenever `playing` is low. While `playing` is high, `core_tick` follows `ref_tick`.
- R8: While `st` stays high, `playing` stays high indefinitely. There is no end of tune.
- R9: If `st` falls before the delay count completes, no start pulse is issued and the block returns to idle.
- R10: After reset, `playing`, `start_pulse`, `stop_pulse` and `core_tick` are low and `tune_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference clock tick enable, one cycle wide |
| sc | input | 1 | Serial shift clock pin |
| si | input | 1 | Serial data pin |
| st | input | 1 | Start/stop level pin |
| core_tick | output | 1 | Gated tick for the sequencer |
| start_pulse | output | 1 | One-cycle start request to the sequencer |
| stop_pulse | output | 1 | High while a stop is being taken |
| playing | output | 1 | High while a tune plays |
| tune_code | output | 4 | Latched selection code |
| tune_num | output | 5 | Selected tune number, 1 to 16 |

## Verification
The bench builds the block with `START_DELAY` set to 16 instead of 128. It drives a reference tick every third cycle. This shorter delay keeps each start short enough to run many start, stop and abort sequences. It still checks the delay window against the tick count rather than the cycle count, so the plus-one tolerance remains visible. The default width and synchronizer depth stay in place, so all sixteen tune codes and the real pin latency are exercised.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_WAIT = 2'd1,
    PS_PLAY = 2'd2
  } play_state_e;
endpackage

// File: rtl/tpc_sync.sv
module tpc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tpc_sel_shift.sv
module tpc_sel_shift #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [SEL_W-1:0] sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= '0;
    else if (shift_en) sel <= {sel[SEL_W-2:0], bit_in};
  end
endmodule

// File: rtl/tpc_start_fsm.sv
module tpc_start_fsm
  import tpc_pkg::*;
#(
  parameter int START_DELAY = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        ref_tick,
  output play_state_e state,
  output logic        start_pulse
);
  localparam int CNT_W = (START_DELAY > 1) ? $clog2(START_DELAY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(START_DELAY - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= PS_IDLE;
      cnt         <= '0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      case (state)
        PS_IDLE: begin
          cnt <= '0;
          if (run) state <= PS_WAIT;
        end
        PS_WAIT: begin
          if (!run) state <= PS_IDLE;
          else if (ref_tick) begin
            if (cnt == LAST) begin
              state       <= PS_PLAY;
              start_pulse <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
        end
        PS_PLAY: if (!run) state <= PS_IDLE;
        default: state <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tune_play_ctrl.sv
module tune_play_ctrl
  import tpc_pkg::*;
#(
  parameter int SEL_W       = 4,
  parameter int START_DELAY = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             sc,
  input  logic             si,
  input  logic             st,
  output logic             core_tick,
  output logic             start_pulse,
  output logic             stop_pulse,
  output logic             playing,
  output logic [SEL_W-1:0] tune_code,
  output logic [SEL_W:0]   tune_num
);
  function automatic logic [SEL_W:0] code_to_num(input logic [SEL_W-1:0] c);
    return {1'b0, c} + 1'b1;
  endfunction

  logic [2:0]  pins_s;
  logic        sc_run, si_run, st_run;
  logic        sc_prev;
  logic        sc_rise;
  logic        idle;
  play_state_e state;

  tpc_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({st, si, sc}), .q(pins_s)
  );
  assign {st_run, si_run, sc_run} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc_prev <= 1'b0;
    else sc_prev <= sc_run;
  end
  assign sc_rise = sc_run & ~sc_prev;

  tpc_start_fsm #(.START_DELAY(START_DELAY)) i_fsm (
    .clk(clk), .rst_n(rst_n), .run(st_run), .ref_tick(ref_tick),
    .state(state), .start_pulse(start_pulse)
  );

  assign idle = (state == PS_IDLE) && !st_run;

  tpc_sel_shift #(.SEL_W(SEL_W)) i_sel (
    .clk(clk), .rst_n(rst_n), .shift_en(sc_rise && idle),
    .bit_in(si_run), .sel(tune_code)
  );

  assign playing    = (state == PS_PLAY);
  assign stop_pulse = !st_run && (state != PS_IDLE);
  assign core_tick  = ref_tick && playing && st_run;
  assign tune_num   = code_to_num(tune_code);
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_run,
  input logic             core_tick,
  input logic             start_pulse,
  input logic             stop_pulse,
  input logic             playing,
  input logic [SEL_W-1:0] tune_code
);
  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  a_r5_play_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(playing) |-> start_pulse);
  a_r7_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !playing |-> !core_tick);
  a_r3_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    playing |=> $stable(tune_code));
  a_r6_stop_ends_play: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !playing);
  a_r8_play_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && st_run) |=> playing);
endmodule

bind tune_play_ctrl tpc_checker #(.SEL_W(SEL_W)) i_tpc_checker (
  .clk(clk), .rst_n(rst_n), .st_run(st_run), .core_tick(core_tick),
  .start_pulse(start_pulse), .stop_pulse(stop_pulse), .playing(playing),
  .tune_code(tune_code)
);

// File: tb/test_tune_play_ctrl.sv
`timescale 1ns/1ps
module test_tune_play_ctrl;
  localparam int DLY = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_tick = 1'b0, sc = 1'b0, si = 1'b0, st = 1'b0;
  logic core_tick, start_pulse, stop_pulse, playing;
  logic [3:0] tune_code;
  logic [4:0] tune_num;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  tune_play_ctrl #(.SEL_W(4), .START_DELAY(DLY), .SYNC_STAGES(2)) i_tune_play_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sc(sc), .si(si), .st(st),
    .core_tick(core_tick), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .playing(playing), .tune_code(tune_code), .tune_num(tune_num)
  );

  initial begin
    forever begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        ref_tick = (k == 0);
      end
    end
  end

  task automatic smp(); @(negedge clk); #1; endtask
  task automatic wait_n(input int n); for (int k = 0; k < n; k++) smp(); endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [7:0] v, input int n);
    for (int b = n - 1; b >= 0; b--) begin
      smp(); si = v[b]; wait_n(2);
      sc = 1'b1; wait_n(3);
      sc = 1'b0; wait_n(3);
    end
    wait_n(4);
  endtask

  task automatic start_and_measure(output int ticks, output int pulses);
    int n = 0;
    pulses = 0;
    smp(); st = 1'b1;
    for (int k = 0; k < 400; k++) begin
      if (start_pulse) begin
        pulses++;
        break;
      end
      if (ref_tick) n++;
      smp();
    end
    ticks = n;
    smp();
    if (start_pulse) pulses++;
  endtask

  task automatic stop_play();
    smp(); st = 1'b0; wait_n(5);
  endtask

  task automatic t_reset();
    chk("R10 playing", playing, 0);
    chk("R10 start_pulse", start_pulse, 0);
    chk("R10 stop_pulse", stop_pulse, 0);
    chk("R10 core_tick", core_tick, 0);
    chk("R10 tune_code", tune_code, 0);
  endtask

  task automatic t_select();
    shift_bits(8'b0011_0110, 6);
    chk("R1 last four bits", tune_code, 6);
    chk("R2 num of code 6", tune_num, 7);
    shift_bits(8'h0F, 4);
    chk("R1 code 15", tune_code, 15);
    chk("R2 num of code 15", tune_num, 16);
    shift_bits(8'h00, 4);
    chk("R2 num of code 0", tune_num, 1);
    shift_bits(8'h09, 4);
    chk("R1 code 9", tune_code, 9);
  endtask

  task automatic t_play();
    int ticks, pulses, ok, mism;
    start_and_measure(ticks, pulses);
    ok = (ticks >= DLY && ticks <= DLY + 1);
    if (!ok) $display("R5 measured ticks=%0d", ticks);
    chk("R5 delay window", ok, 1);
    chk("R5 single pulse", pulses, 1);
    chk("R5 playing after start", playing, 1);
    chk("R4 tune num at start", tune_num, 10);
    mism = 0;
    for (int k = 0; k < 300; k++) begin
      smp();
      if (core_tick != ref_tick) mism++;
      if (!playing) mism++;
    end
    chk("R7 R8 tick pass and hold", mism, 0);
    shift_bits(8'h05, 4);
    chk("R3 shift ignored in play", tune_code, 9);
  endtask

  task automatic t_stop();
    int ticks_seen;
    smp(); st = 1'b0;
    ticks_seen = 0;
    wait_n(3);
    chk("R6 playing dropped", playing, 0);
    for (int k = 0; k < 30; k++) begin
      smp();
      if (core_tick) ticks_seen++;
    end
    chk("R6 R7 no ticks after stop", ticks_seen, 0);
    chk("R4 code kept after stop", tune_code, 9);
  endtask

  task automatic t_abort();
    int pulses = 0;
    smp(); st = 1'b1;
    wait_n(10);
    shift_bits(8'h03, 1);
    st = 1'b0;
    for (int k = 0; k < 120; k++) begin
      smp();
      if (start_pulse || playing) pulses++;
    end
    chk("R9 no start on abort", pulses, 0);
    chk("R3 shift ignored in wait", tune_code, 9);
  endtask

  task automatic t_restart();
    int ticks, pulses;
    start_and_measure(ticks, pulses);
    chk("R4 restart pulses", pulses, 1);
    chk("R4 same tune on restart", tune_num, 10);
    stop_play();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_select();
    t_play();
    t_stop();
    t_abort();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule